// File: doc/BRIEF.md
# Pin Event Detector with Latched Status

This block sits behind the debounce filter of one general-purpose pin. It watches the filtered level and turns the selected condition into a sticky interrupt status bit. The condition is a falling edge, a rising edge, either edge, a low level or a high level. The same detection event also sets a separate wake status bit, but only when the wake enable for the current power state is on. A registered interrupt request leaves the block only while the status is set, the pin's interrupt enable is on and the pin is unmasked.

Software sees one 32-bit word per pin. The configuration fields are written directly. The two status bits are cleared by writing 1 to them. A read-only bit reports the sampled input level. The output-enable and output-value bits are stored in the same word and drive the pad controls only. The per-pin words are aggregated elsewhere, and the bus itself is also outside this block.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset the read word is 0 (with the pin low), and `irqReq`, `wakeFlag`, `padOe` and `padOut` are 0.
- R2: Edge sensing applies when bit 0 is 0. The polarity field in bits 2:1 selects the event: 00 latches a falling edge, 01 a rising edge and 10 either edge, while 11 latches nothing. The interrupt status (bit 28) reads 1 on the first clock edge after the transition.
- R3: Level sensing applies when bit 0 is 1. Code 00 latches while the pin is low and code 01 latches while the pin is high; codes 10 and 11 latch nothing. Writing 1 to bit 28 does not clear the status while the active level persists.
- R4: When the interrupt enable (bit 3) is 0, no event is latched in either status bit, and a status bit that is already set stays set.
- R5: A write with bit 28 at 1 clears the interrupt status, and a write with bit 28 at 0 leaves it alone. A detection on the same clock edge as the clear wins, so the status stays set.
- R6: `irqReq` equals the AND of the interrupt status, the unmask bit (bit 4, 1 means unmasked) and the enable bit, registered once.
- R7: `powerState` chooses one wake enable: 0 selects bit 7, 1 selects bit 8, 2 selects bit 9, and 3 selects none. A detection that latches the interrupt status also sets the wake status (bit 29, shown on `wakeFlag`) when the chosen enable is 1. Bit 29 is cleared by writing 1 to it, independently of bit 28.
- R8: `padOe` follows bit 5 and `padOut` follows bit 6 from the clock edge that writes them.
- R9: Bit 16 reads the pin level sampled on the previous clock edge and ignores writes. Bits 9:0 read back as written. Every other bit except 28 and 29 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinLevel | input | 1 | Filtered pin level |
| powerState | input | 2 | Current low-power state: 0, 1 or 2, or 3 for running |
| regWrEn | input | 1 | Write strobe for the pin word |
| regWrData | input | 32 | Write data for the pin word |
| regRdData | output | 32 | Current pin word |
| irqReq | output | 1 | Registered interrupt request |
| wakeFlag | output | 1 | Wake status bit |
| padOe | output | 1 | Pad output enable |
| padOut | output | 1 | Pad output value |

## Verification
Assertions check several rules on every cycle. A detection always leaves the interrupt status set on the next edge, and a clear with no competing detection always empties it. The request tracks the registered AND of status, unmask and enable. A wake status never rises without a qualifying detection, and level sensing with a both-edges or undefined code never detects anything. Other behaviour only shows up across a sequence of stimulus, so the directed scenarios cover it. That includes which transition each polarity code selects and whether a level-mode status survives a clear while the level stays active. The scenarios also cover the mapping from power state to wake enable, status that persists after the enable drops, and readback that ignores writes to the read-only bits.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int REG_W        = 32;
  localparam int NUM_WAKE     = 3;
  localparam int PS_W         = 2;
  localparam int PIN_STS_BIT  = 16;
  localparam int INT_STS_BIT  = 28;
  localparam int WAKE_STS_BIT = 29;
  localparam int OE_BIT       = 5;
  localparam int OV_BIT       = 6;

  typedef enum logic [1:0] {
    POL_LOW  = 2'b00,
    POL_HIGH = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } polSel_e;

  // packed from MSB: wake enables in 9:7, trigger mode in bit 0
  typedef struct packed {
    logic [NUM_WAKE-1:0] wakeEn;
    logic                outVal;
    logic                outEn;
    logic                unmask;
    logic                intEn;
    polSel_e             pol;
    logic                trigLevel;
  } pinCfg_t;

  localparam int CFG_W = $bits(pinCfg_t);

  typedef struct packed {
    logic loadCfg;
    logic setInt;
    logic setWake;
    logic clrInt;
    logic clrWake;
  } pinStrb_t;

endpackage

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NW  = NUM_WAKE,
  parameter int PSW = PS_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           pinLevel,
  input  logic           pinQ,
  input  logic           trigLevel,
  input  polSel_e        pol,
  input  logic           intEn,
  input  logic [NW-1:0]  wakeEn,
  input  logic [PSW-1:0] powerState,
  input  logic           regWrEn,
  input  logic           wrClrInt,
  input  logic           wrClrWake,
  output pinStrb_t       strb
);

  logic riseEv;
  logic fallEv;
  logic edgeHit;
  logic levelHit;
  logic hit;
  logic [NW-1:0] wakeMatch;
  logic wakeOn;

  assign riseEv = pinLevel & ~pinQ;
  assign fallEv = ~pinLevel & pinQ;

  always_comb begin
    case (pol)
      POL_LOW:  edgeHit = fallEv;
      POL_HIGH: edgeHit = riseEv;
      POL_BOTH: edgeHit = riseEv | fallEv;
      default:  edgeHit = 1'b0;
    endcase
  end

  always_comb begin
    case (pol)
      POL_LOW:  levelHit = ~pinLevel;
      POL_HIGH: levelHit = pinLevel;
      default:  levelHit = 1'b0;
    endcase
  end

  assign hit = intEn & (trigLevel ? levelHit : edgeHit);

  for (genvar gi = 0; gi < NW; gi++) begin : gWakeSel
    assign wakeMatch[gi] = (powerState == PSW'(gi)) & wakeEn[gi];
  end
  assign wakeOn = |wakeMatch;

  always_comb begin
    strb         = '0;
    strb.loadCfg = regWrEn;
    strb.setInt  = hit;
    strb.setWake = hit & wakeOn;
    strb.clrInt  = regWrEn & wrClrInt;
    strb.clrWake = regWrEn & wrClrWake;
  end

  // R3: level sensing with code 10 or 11 never detects
  assert_level_no_detect_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trigLevel && (pol == POL_BOTH || pol == POL_RSVD)) |-> !strb.setInt);

  // R7: wake only rides on an interrupt detection
  assert_wake_needs_detect_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWake |-> strb.setInt);

  // R4: disabled pin raises no set strobe
  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !(strb.setInt || strb.setWake));

endmodule

// File: rtl/pin_irq_dp.sv
module pin_irq_dp
  import pin_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinLevel,
  input  pinStrb_t         strb,
  input  logic [CFG_W-1:0] wrCfg,
  output pinCfg_t          cfg,
  output logic             pinQ,
  output logic [REG_W-1:0] regRdData,
  output logic             irqReq,
  output logic             wakeFlag,
  output logic             padOe,
  output logic             padOut
);

  pinCfg_t cfgQ;
  logic    stsInt;
  logic    stsWake;
  logic    irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      pinQ    <= 1'b0;
      stsInt  <= 1'b0;
      stsWake <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      pinQ <= pinLevel;
      if (strb.loadCfg) cfgQ <= pinCfg_t'(wrCfg);
      if (strb.setInt)       stsInt <= 1'b1;
      else if (strb.clrInt)  stsInt <= 1'b0;
      if (strb.setWake)      stsWake <= 1'b1;
      else if (strb.clrWake) stsWake <= 1'b0;
      irqQ <= stsInt & cfgQ.unmask & cfgQ.intEn;
    end
  end

  always_comb begin
    regRdData               = '0;
    regRdData[CFG_W-1:0]    = cfgQ;
    regRdData[PIN_STS_BIT]  = pinQ;
    regRdData[INT_STS_BIT]  = stsInt;
    regRdData[WAKE_STS_BIT] = stsWake;
  end

  assign cfg      = cfgQ;
  assign irqReq   = irqQ;
  assign wakeFlag = stsWake;
  assign padOe    = cfgQ.outEn;
  assign padOut   = cfgQ.outVal;

  // R5: a detection always leaves the status set
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.setInt |=> stsInt);

  // R5: an uncontested clear empties the status
  assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrInt && !strb.setInt) |=> !stsInt);

  // R6: request asserted one cycle after the qualified status
  assert_req_on_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stsInt && cfgQ.unmask && cfgQ.intEn) |=> irqReq);

  // R6: request dropped one cycle after qualification ends
  assert_req_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(stsInt && cfgQ.unmask && cfgQ.intEn) |=> !irqReq);

  // R7: wake status only rises after a wake strobe
  assert_wake_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsWake) |-> $past(strb.setWake));

  // R8: pad controls take the written bits
  assert_pad_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCfg |=> (padOe == $past(wrCfg[OE_BIT]) && padOut == $past(wrCfg[OV_BIT])));

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int PSW = PS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinLevel,
  input  logic [PSW-1:0]   powerState,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irqReq,
  output logic             wakeFlag,
  output logic             padOe,
  output logic             padOut
);

  pinStrb_t strb;
  pinCfg_t  cfg;
  logic     pinQ;
  logic     unusedWrBits;

  // read-only and reserved write bits carry no meaning
  assign unusedWrBits = ^{regWrData[REG_W-1:WAKE_STS_BIT+1],
                          regWrData[INT_STS_BIT-1:CFG_W]};

  pin_irq_ctrl #(
    .NW  (NUM_WAKE),
    .PSW (PSW)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pinLevel   (pinLevel),
    .pinQ       (pinQ),
    .trigLevel  (cfg.trigLevel),
    .pol        (cfg.pol),
    .intEn      (cfg.intEn),
    .wakeEn     (cfg.wakeEn),
    .powerState (powerState),
    .regWrEn    (regWrEn),
    .wrClrInt   (regWrData[INT_STS_BIT]),
    .wrClrWake  (regWrData[WAKE_STS_BIT]),
    .strb       (strb)
  );

  pin_irq_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinLevel  (pinLevel),
    .strb      (strb),
    .wrCfg     (regWrData[CFG_W-1:0]),
    .cfg       (cfg),
    .pinQ      (pinQ),
    .regRdData (regRdData),
    .irqReq    (irqReq),
    .wakeFlag  (wakeFlag),
    .padOe     (padOe),
    .padOut    (padOut)
  );

endmodule

// File: tb/pin_irq_detect_bench.sv
module pin_irq_detect_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinLevel = 1'b0;
  logic [1:0]  powerState = 2'd3;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqReq;
  logic        wakeFlag;
  logic        padOe;
  logic        padOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [31:0] CLR_INT  = 32'h1000_0000;
  localparam logic [31:0] CLR_WAKE = 32'h2000_0000;

  always #5 clk = ~clk;

  pin_irq_detect u_pin_irq_detect (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .powerState(powerState),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqReq(irqReq), .wakeFlag(wakeFlag), .padOe(padOe), .padOut(padOut)
  );

  function automatic logic [31:0] mkCfg(input logic lvl, input logic [1:0] pol,
      input logic en, input logic um, input logic [2:0] wk, input logic oe, input logic ov);
    return {22'd0, wk, ov, oe, um, en, pol, lvl};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  task automatic pinTo(input logic v);
    @(negedge clk);
    pinLevel = v;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 word", regRdData, 32'h0);
    chk("R1 irqReq", {31'd0, irqReq}, 32'h0);
    chk("R1 wakeFlag", {31'd0, wakeFlag}, 32'h0);
    chk("R1 pads", {30'd0, padOe, padOut}, 32'h0);
  endtask

  task automatic testEdgeRise();
    logic [31:0] c = mkCfg(1'b0, 2'b01, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0);
    wr(c);
    pinTo(1'b1);
    chk("R2 rise sets", {31'd0, regRdData[28]}, 32'h1);
    chk("R6 req one cycle late", {31'd0, irqReq}, 32'h0);
    idle(1);
    chk("R6 req asserted", {31'd0, irqReq}, 32'h1);
    wr(c | CLR_INT);
    chk("R5 w1c clears", {31'd0, regRdData[28]}, 32'h0);
    idle(1);
    chk("R6 req dropped", {31'd0, irqReq}, 32'h0);
    pinTo(1'b0);
    chk("R2 rise code ignores fall", {31'd0, regRdData[28]}, 32'h0);
  endtask

  task automatic testEdgeFall();
    logic [31:0] c = mkCfg(1'b0, 2'b00, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0);
    wr(c);
    pinTo(1'b1);
    chk("R2 fall code ignores rise", {31'd0, regRdData[28]}, 32'h0);
    pinTo(1'b0);
    chk("R2 fall sets", {31'd0, regRdData[28]}, 32'h1);
    wr(c | CLR_INT);
  endtask

  task automatic testBoth();
    logic [31:0] c = mkCfg(1'b0, 2'b10, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0);
    wr(c);
    pinTo(1'b1);
    chk("R2 both on rise", {31'd0, regRdData[28]}, 32'h1);
    wr(c | CLR_INT);
    pinTo(1'b0);
    chk("R2 both on fall", {31'd0, regRdData[28]}, 32'h1);
    wr(c | CLR_INT);
    chk("R5 cleared after both", {31'd0, regRdData[28]}, 32'h0);
  endtask

  task automatic testReserved();
    wr(mkCfg(1'b0, 2'b11, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0));
    pinTo(1'b1);
    pinTo(1'b0);
    chk("R2 code 11 latches nothing", {31'd0, regRdData[28]}, 32'h0);
    chk("R2 code 11 no request", {31'd0, irqReq}, 32'h0);
  endtask

  task automatic testLevel();
    logic [31:0] hi = mkCfg(1'b1, 2'b01, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0);
    logic [31:0] lo = mkCfg(1'b1, 2'b00, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0);
    logic [31:0] bt = mkCfg(1'b1, 2'b10, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0);
    wr(hi);
    idle(1);
    chk("R3 high level idle while low", {31'd0, regRdData[28]}, 32'h0);
    pinTo(1'b1);
    chk("R3 high level sets", {31'd0, regRdData[28]}, 32'h1);
    wr(hi | CLR_INT);
    chk("R3 clear blocked while active", {31'd0, regRdData[28]}, 32'h1);
    pinTo(1'b0);
    wr(hi | CLR_INT);
    chk("R3 clear after level ends", {31'd0, regRdData[28]}, 32'h0);
    wr(lo);
    idle(1);
    chk("R3 low level sets", {31'd0, regRdData[28]}, 32'h1);
    pinTo(1'b1);
    wr(lo | CLR_INT);
    chk("R3 low level cleared", {31'd0, regRdData[28]}, 32'h0);
    wr(bt);
    pinTo(1'b0);
    idle(1);
    chk("R3 level code 10 idle low", {31'd0, regRdData[28]}, 32'h0);
    pinTo(1'b1);
    idle(1);
    chk("R3 level code 10 idle high", {31'd0, regRdData[28]}, 32'h0);
  endtask

  task automatic testDisable();
    logic [31:0] off = mkCfg(1'b0, 2'b01, 1'b0, 1'b1, 3'b000, 1'b0, 1'b0);
    logic [31:0] on  = mkCfg(1'b0, 2'b01, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0);
    wr(off);
    pinTo(1'b0);
    pinTo(1'b1);
    chk("R4 disabled no latch", {31'd0, regRdData[28]}, 32'h0);
    wr(on);
    pinTo(1'b0);
    pinTo(1'b1);
    chk("R4 enabled latches", {31'd0, regRdData[28]}, 32'h1);
    wr(off);
    chk("R4 status kept after disable", {31'd0, regRdData[28]}, 32'h1);
    idle(1);
    chk("R6 disable gates request", {31'd0, irqReq}, 32'h0);
    wr(off | CLR_INT);
    chk("R5 clear while disabled", {31'd0, regRdData[28]}, 32'h0);
  endtask

  task automatic testMask();
    logic [31:0] msk = mkCfg(1'b0, 2'b01, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0);
    logic [31:0] um  = mkCfg(1'b0, 2'b01, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0);
    wr(msk);
    pinTo(1'b0);
    pinTo(1'b1);
    chk("R6 masked still latches", {31'd0, regRdData[28]}, 32'h1);
    idle(2);
    chk("R6 masked no request", {31'd0, irqReq}, 32'h0);
    wr(um);
    idle(1);
    chk("R6 unmask raises request", {31'd0, irqReq}, 32'h1);
    wr(um | CLR_INT);
  endtask

  task automatic testCollide();
    logic [31:0] c = mkCfg(1'b0, 2'b01, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0);
    wr(c);
    pinTo(1'b0);
    @(negedge clk);
    pinLevel = 1'b1;
    regWrEn = 1'b1;
    regWrData = c | CLR_INT;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
    chk("R5 set beats clear", {31'd0, regRdData[28]}, 32'h1);
    wr(c);
    chk("R5 write 0 keeps status", {31'd0, regRdData[28]}, 32'h1);
    wr(c | CLR_INT);
    chk("R5 w1c clears", {31'd0, regRdData[28]}, 32'h0);
  endtask

  task automatic toggle();
    pinTo(1'b0);
    pinTo(1'b1);
  endtask

  task automatic testWake();
    logic [31:0] s3  = mkCfg(1'b0, 2'b01, 1'b1, 1'b1, 3'b010, 1'b0, 1'b0);
    logic [31:0] s45 = mkCfg(1'b0, 2'b01, 1'b1, 1'b1, 3'b100, 1'b0, 1'b0);
    logic [31:0] all = mkCfg(1'b0, 2'b01, 1'b1, 1'b1, 3'b111, 1'b0, 1'b0);
    powerState = 2'd1;
    wr(s3);
    toggle();
    chk("R7 wake set in state 1", {30'd0, regRdData[29:28]}, 32'h3);
    chk("R7 wakeFlag", {31'd0, wakeFlag}, 32'h1);
    wr(s3 | CLR_INT);
    chk("R7 int clear keeps wake", {30'd0, regRdData[29:28]}, 32'h2);
    wr(s3 | CLR_WAKE);
    chk("R7 wake w1c", {30'd0, regRdData[29:28]}, 32'h0);
    @(negedge clk);
    powerState = 2'd0;
    toggle();
    chk("R7 other state no wake", {30'd0, regRdData[29:28]}, 32'h1);
    wr(s3 | CLR_INT | CLR_WAKE);
    @(negedge clk);
    powerState = 2'd2;
    wr(s45);
    toggle();
    chk("R7 wake set in state 2", {30'd0, regRdData[29:28]}, 32'h3);
    wr(s45 | CLR_INT | CLR_WAKE);
    @(negedge clk);
    powerState = 2'd3;
    wr(all);
    toggle();
    chk("R7 running state no wake", {30'd0, regRdData[29:28]}, 32'h1);
    wr(all | CLR_INT | CLR_WAKE);
  endtask

  task automatic testPads();
    wr(mkCfg(1'b0, 2'b00, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0));
    chk("R8 oe only", {30'd0, padOe, padOut}, 32'h2);
    wr(mkCfg(1'b0, 2'b00, 1'b0, 1'b0, 3'b000, 1'b1, 1'b1));
    chk("R8 oe and value", {30'd0, padOe, padOut}, 32'h3);
    wr(mkCfg(1'b0, 2'b00, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0));
    chk("R8 both off", {30'd0, padOe, padOut}, 32'h0);
  endtask

  task automatic testPinSts();
    logic [31:0] c = mkCfg(1'b0, 2'b10, 1'b0, 1'b1, 3'b101, 1'b1, 1'b0);
    wr(c);
    chk("R9 readback with pin high", regRdData, 32'h0001_02B4);
    pinTo(1'b0);
    chk("R9 pin low", regRdData, 32'h0000_02B4);
    wr(c | 32'hC0F1_0000);
    chk("R9 read-only and reserved ignored", regRdData, 32'h0000_02B4);
    @(negedge clk);
    pinLevel = 1'b1;
    #1;
    chk("R9 sampled not live", {31'd0, regRdData[16]}, 32'h0);
    @(negedge clk);
    chk("R9 sample after edge", {31'd0, regRdData[16]}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEdgeRise();
    testEdgeFall();
    testBoth();
    testReserved();
    testLevel();
    testDisable();
    testMask();
    testCollide();
    testWake();
    testPads();
    testPinSts();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule